// File: doc/BRIEF.md
# Layered Multiplexer Word Shifter

This block moves a 64-bit word left or right by any distance from 0 to 63 bit positions in a single combinational pass, filling emptied positions with zeros. It is meant to sit inside an execution path where the shifted result must be ready in the same cycle as its operands. The requested distance is split between two kinds of layer: a fine part that handles distances below one 16-bit group, and a coarse part that moves whole 16-bit groups.

The fine part is two layers of 4-input multiplexers. The first layer offsets by 0, 1, 2 or 3 positions and the second by 0, 4, 8 or 12. The coarse part is three layers of 3-input multiplexers. Each of these layers holds the word, moves it one group toward the top, or moves it one group toward the bottom. The two upper bits of the distance, read as a group count, enable that many coarse layers in the requested direction. No layer carries a bit further than 16 positions, so every wire crossing in the datapath stays short.

The block has no clock and no handshake. The output follows the inputs combinationally.

Top module: `shf_tree_top`

## Requirements
- R1: With `dir_i` = 0, `data_o` equals `data_i` moved toward the most significant end by `amt_i` positions.
- R2: With `dir_i` = 1, `data_o` equals `data_i` moved toward the least significant end by `amt_i` positions.
- R3: An `amt_i` of 0 returns `data_i` unchanged in either direction.
- R4: Every position vacated by the move reads 0: the low `amt_i` bits for `dir_i` = 0, and the high `amt_i` bits for `dir_i` = 1.
- R5: Distances 0 to 15 (`amt_i[5:4]` = 0) are served by the two fine layers alone, which use `amt_i[1:0]` for steps of 1 and `amt_i[3:2]` for steps of 4.
- R6: Distances that are multiples of 16 (`amt_i[3:0]` = 0) are served by the coarse layers alone, each moving one 16-bit group. `amt_i[5:4]` gives the group count.
- R7: The output is combinational: it settles to its new value after an input change without any clock edge.
- R8: At the extreme distance of 63, only bit 0 (left) or bit 63 (right) of the input survives, landing at the opposite end.
- R9: The output never has more set bits than the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Word to be shifted |
| amt_i | input | 6 | Shift distance in bit positions |
| dir_i | input | 1 | 0 = toward MSB, 1 = toward LSB |
| data_o | output | 64 | Shifted word, zero filled |

## Verification
The hardest situation to reach is a distance that needs all five layers at once: a fine offset in both fine layers together with all three coarse layers enabled. In that case a bit crosses a group boundary inside the fine stage and is then moved again by the coarse layers. The stimulus sweeps every distance from 0 to 63 in both directions. Each distance is applied to several data patterns, including walking single bits at group edges and random words. This exercises every combination of fine offset and group count, and every boundary crossing.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned GROUP_W = 16;

  typedef enum logic [1:0] {
    GRP_HOLD = 2'd0,
    GRP_UP   = 2'd1,
    GRP_DOWN = 2'd2
  } grp_sel_e;
endpackage

// File: rtl/shf_fine_layer.sv
module shf_fine_layer #(
  parameter int unsigned W    = 64,
  parameter int unsigned STEP = 1
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   sel,
  input  logic         dir,
  output logic [W-1:0] dout
);
  localparam int NCH = 4;

  logic [NCH-1:0] cand_up [W];
  logic [NCH-1:0] cand_dn [W];

  for (genvar i = 0; i < W; i++) begin : g_bit
    for (genvar s = 0; s < NCH; s++) begin : g_ch
      localparam int LO = i - s * STEP;
      localparam int HI = i + s * STEP;
      if (LO >= 0) begin : g_lo
        assign cand_up[i][s] = din[LO];
      end else begin : g_lo_z
        assign cand_up[i][s] = 1'b0;
      end
      if (HI < W) begin : g_hi
        assign cand_dn[i][s] = din[HI];
      end else begin : g_hi_z
        assign cand_dn[i][s] = 1'b0;
      end
    end
    assign dout[i] = dir ? cand_dn[i][sel] : cand_up[i][sel];
  end
endmodule

// File: rtl/shf_coarse_layer.sv
module shf_coarse_layer
  import shf_pkg::*;
#(
  parameter int unsigned W = 64,
  parameter int unsigned G = 16
) (
  input  logic [W-1:0] din,
  input  grp_sel_e     sel,
  output logic [W-1:0] dout
);
  logic [W-1:0] up_w;
  logic [W-1:0] dn_w;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= G) begin : g_up
      assign up_w[i] = din[i-G];
    end else begin : g_up_z
      assign up_w[i] = 1'b0;
    end
    if (i + G < W) begin : g_dn
      assign dn_w[i] = din[i+G];
    end else begin : g_dn_z
      assign dn_w[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      GRP_UP:   dout = up_w;
      GRP_DOWN: dout = dn_w;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/shf_tree_top.sv
module shf_tree_top
  import shf_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned G = GROUP_W
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 dir_i,
  output logic [W-1:0]         data_o
);
  localparam int AMT_W   = $clog2(W);
  localparam int FINE_W  = $clog2(G);
  localparam int NFINE   = FINE_W / 2;
  localparam int GCNT_W  = AMT_W - FINE_W;
  localparam int NCOARSE = W / G - 1;

  logic [W-1:0] fine_q [NFINE+1];
  logic [W-1:0] crs_q  [NCOARSE+1];
  logic [GCNT_W-1:0] grp_cnt;

  assign fine_q[0] = data_i;
  assign grp_cnt   = amt_i[AMT_W-1:FINE_W];

  for (genvar k = 0; k < NFINE; k++) begin : g_fine
    shf_fine_layer #(.W(W), .STEP(4 ** k)) u_fine (
      .din  (fine_q[k]),
      .sel  (amt_i[2*k+1:2*k]),
      .dir  (dir_i),
      .dout (fine_q[k+1])
    );
  end

  assign crs_q[0] = fine_q[NFINE];

  for (genvar c = 0; c < NCOARSE; c++) begin : g_coarse
    grp_sel_e csel;
    always_comb begin
      if (int'(grp_cnt) > c) csel = dir_i ? GRP_DOWN : GRP_UP;
      else                   csel = GRP_HOLD;
    end
    shf_coarse_layer #(.W(W), .G(G)) u_crs (
      .din  (crs_q[c]),
      .sel  (csel),
      .dout (crs_q[c+1])
    );
  end

  assign data_o = crs_q[NCOARSE];
endmodule

// File: rtl/shf_tree_chk.sv
module shf_tree_chk #(
  parameter int unsigned W = 64
) (
  input logic [W-1:0]         data_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic                 dir_i,
  input logic [W-1:0]         data_o
);
  logic [W-1:0] low_mask;
  logic [W-1:0] high_mask;

  always_comb begin
    low_mask  = (W'(1) << amt_i) - W'(1);
    high_mask = ~({W{1'b1}} >> amt_i);
  end

  always_comb begin
    if (!$isunknown({data_i, amt_i, dir_i})) begin
      // R3
      a_r3_zero_amount: assert (amt_i != '0 || data_o == data_i);
      // R4
      a_r4_fill_low: assert (dir_i || (data_o & low_mask) == '0);
      a_r4_fill_high: assert (!dir_i || (data_o & high_mask) == '0);
      // R9
      a_r9_no_gain: assert ($countones(data_o) <= $countones(data_i));
      // R8
      a_r8_extreme: assert (amt_i != {$clog2(W){1'b1}} ||
                            data_o == (dir_i ? {{(W-1){1'b0}}, data_i[W-1]}
                                             : {data_i[0], {(W-1){1'b0}}}));
    end
  end
endmodule

bind shf_tree_top shf_tree_chk #(.W(W)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .dir_i  (dir_i),
  .data_o (data_o)
);

// File: tb/sim_shf_tree_top.sv
module sim_shf_tree_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] data_i = '0;
  logic [5:0]  amt_i  = '0;
  logic        dir_i  = 1'b0;
  logic [63:0] data_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shf_tree_top u0 (.data_i(data_i), .amt_i(amt_i), .dir_i(dir_i), .data_o(data_o));

  task automatic check(input string tag, input logic [63:0] exp);
    checks++;
    if (data_o !== exp) begin
      fails++;
      $display("FAIL %s amt=%0d dir=%0d got=%h exp=%h", tag, amt_i, dir_i, data_o, exp);
    end
  endtask

  function automatic string tag_for(input int a, input bit d);
    if (a == 0)       return "R3";
    if (a == 63)      return "R8";
    if (a < 16)       return "R5";
    if (a % 16 == 0)  return "R6";
    return d ? "R2" : "R1";
  endfunction

  task automatic apply(input logic [63:0] d, input int a, input bit dr);
    logic [63:0] exp;
    @(negedge clk);
    data_i = d; amt_i = 6'(a); dir_i = dr;
    #1;
    exp = dr ? (d >> a) : (d << a);
    check(tag_for(a, dr), exp);
    // R4: vacated positions are zero
    checks++;
    if (dr ? ((a != 0) && ((data_o >> (64 - a)) != 0))
           : ((data_o & ((64'h1 << a) - 64'h1)) != 0)) begin
      fails++;
      $display("FAIL R4 amt=%0d dir=%0d got=%h exp=zero fill", a, dr, data_o);
    end
    // R9
    checks++;
    if ($countones(data_o) > $countones(d)) begin
      fails++;
      $display("FAIL R9 got=%0d ones exp<=%0d", $countones(data_o), $countones(d));
    end
  endtask

  initial begin
    logic [63:0] pats [8];
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'h0001_8000_0001_8000;
    pats[3] = 64'hA5A5_5A5A_0F0F_F0F0;
    for (int k = 4; k < 8; k++) pats[k] = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: inputs at zero give zero output
    @(negedge clk);
    checks++;
    if (data_o !== 64'h0) begin
      fails++;
      $display("FAIL R3 reset got=%h exp=0", data_o);
    end
    for (int dr = 0; dr < 2; dr++)
      for (int a = 0; a < 64; a++)
        for (int p = 0; p < 8; p++)
          apply(pats[p], a, dr[0]);
    // R7: combinational response without an edge
    @(negedge clk);
    data_i = 64'h1; amt_i = 6'd40; dir_i = 1'b0;
    #1;
    data_i = 64'h3;
    #1;
    check("R7", 64'h3 << 40);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=timeout exp=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule